// File: doc/BRIEF.md
# Floating-point subtract special-case resolver

This purely combinational block sits ahead of a floating-point subtract datapath and computes `dst - src` for all operand pairs whose difference follows from classification alone. Each operand is sorted into zero, denormal, normal finite, infinity, quiet NaN or signaling NaN. NaNs, infinities, zeros and identical operands are resolved in place, and the block drives the final result together with the invalid and denormal flags.

Any remaining pair has two finite nonzero operands that differ. For such a pair the block raises `pass_thru`, and the ordinary subtract datapath takes over. A rounding-mode input selects the sign of an exact zero difference. A source-is-integer input marks a source converted from an integer, whose zero is always positive.

Top module: `fsub_special`

## Requirements
- R1: `pass_thru` is 1 only when both operands are finite and nonzero (denormals count as nonzero) and are not bit-identical after the R8 adjustment. While `pass_thru` is 1, `result` is all zeros and `flag_invalid` is 0.
- R2: A NaN has all exponent bits set and a nonzero mantissa. If either operand is a NaN, the result is that NaN with its top mantissa bit (bit MAN_W-1) forced to 1 and its sign and other payload bits kept. The destination wins when both operands are NaNs.
- R3: A signaling NaN has its top mantissa bit at 0. A signaling NaN in either operand sets `flag_invalid`.
- R4: If both operands are infinities of the same sign, `flag_invalid` is set and the result is the default NaN. The default NaN has sign 1, all exponent bits 1, top mantissa bit 1 and all other mantissa bits 0 (0xFFF8000000000000 at default widths).
- R5: This rule covers an infinite destination with a non-NaN source of opposite sign or finite value, and an infinite source with a finite destination. An infinite destination yields the destination. Otherwise the infinite source is returned with its sign inverted.
- R6: Rounding mode is encoded 00 nearest, 01 toward negative infinity, 10 toward positive infinity, 11 toward zero. Two zeros of equal sign, or two identical finite operands, give +0 in every mode except 01, which gives -0.
- R7: Two zeros of opposite sign give the destination zero, whatever the rounding mode (+0 - -0 = +0, -0 - +0 = -0).
- R8: With `src_is_int` at 1, a zero source is taken as +0 whatever its sign bit.
- R9: A zero destination with a nonzero finite source gives the source with its sign inverted. A nonzero finite destination with a zero source gives the destination.
- R10: A denormal source (exponent 0, mantissa nonzero) sets `flag_denorm`. A denormal destination does not.
- R11: `flag_invalid` is 0 in every case not covered by R3 or R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dst_op | input | 1+EXP_W+MAN_W | Destination (minuend) operand |
| src_op | input | 1+EXP_W+MAN_W | Source (subtrahend) operand |
| rnd_mode | input | 2 | Rounding mode, used for the sign of an exact zero |
| src_is_int | input | 1 | Source was converted from an integer |
| pass_thru | output | 1 | Operands must go to the normal subtract datapath |
| result | output | 1+EXP_W+MAN_W | Resolved difference (zero while pass_thru is 1) |
| flag_invalid | output | 1 | Invalid-operand exception |
| flag_denorm | output | 1 | Denormal source exception |

## Verification
The bench builds the block with its default widths, EXP_W=11 and MAN_W=52, which give IEEE double precision. At these widths the operands can be written as familiar 64-bit encodings such as 1.0, infinities, the default NaN, a smallest denormal, and signaling and quiet NaNs with payloads. The bench can then state expected results exactly. The scenarios cover each rounding mode on exact zeros, the NaN priority order, the sign of a negated infinity, and the integer-zero source against a negative-zero floating source.

// File: rtl/fsub_special.sv
module fsub_special #(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52
) (
  input  logic [EXP_W+MAN_W:0] dst_op,
  input  logic [EXP_W+MAN_W:0] src_op,
  input  logic [1:0]           rnd_mode,
  input  logic                 src_is_int,
  output logic                 pass_thru,
  output logic [EXP_W+MAN_W:0] result,
  output logic                 flag_invalid,
  output logic                 flag_denorm
);
  localparam int W = 1 + EXP_W + MAN_W;

  logic [EXP_W-1:0] d_e, s_e;
  logic [MAN_W-1:0] d_m, s_m;
  assign d_e = dst_op[W-2:MAN_W];
  assign s_e = src_op[W-2:MAN_W];
  assign d_m = dst_op[MAN_W-1:0];
  assign s_m = src_op[MAN_W-1:0];

  logic d_nan, d_snan, d_inf, d_zero;
  logic s_nan, s_snan, s_inf, s_zero, s_sign;
  assign d_nan  = (&d_e) & (|d_m);
  assign d_snan = d_nan & ~d_m[MAN_W-1];
  assign d_inf  = (&d_e) & ~(|d_m);
  assign d_zero = ~(|d_e) & ~(|d_m);
  assign s_nan  = (&s_e) & (|s_m);
  assign s_snan = s_nan & ~s_m[MAN_W-1];
  assign s_inf  = (&s_e) & ~(|s_m);
  assign s_zero = ~(|s_e) & ~(|s_m);
  assign s_sign = src_op[W-1] & ~(src_is_int & s_zero);

  logic [W-1:0] src_eff, qnan_def, zero_rm, quiet_bit;
  assign src_eff   = {s_sign, src_op[W-2:0]};
  assign quiet_bit = {{(EXP_W+1){1'b0}}, 1'b1, {(MAN_W-1){1'b0}}};
  assign qnan_def  = {1'b1, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};
  assign zero_rm   = {rnd_mode == 2'b01, {(W-1){1'b0}}};

  assign flag_denorm = ~(|s_e) & (|s_m);

  always_comb begin
    pass_thru    = 1'b0;
    flag_invalid = 1'b0;
    result       = '0;
    if (d_nan || s_nan) begin
      result       = (d_nan ? dst_op : src_op) | quiet_bit;
      flag_invalid = d_snan | s_snan;
    end else if (d_inf && s_inf && (dst_op[W-1] == s_sign)) begin
      result       = qnan_def;
      flag_invalid = 1'b1;
    end else if (d_inf) begin
      result = dst_op;
    end else if (s_inf) begin
      result = {~s_sign, src_op[W-2:0]};
    end else if (d_zero && s_zero) begin
      result = (dst_op[W-1] != s_sign) ? dst_op : zero_rm;
    end else if (d_zero) begin
      result = {~s_sign, src_op[W-2:0]};
    end else if (s_zero) begin
      result = dst_op;
    end else if (dst_op == src_eff) begin
      result = zero_rm;
    end else begin
      pass_thru = 1'b1;
    end
  end

  always_comb begin
    if (!$isunknown({dst_op, src_op, rnd_mode, src_is_int})) begin
      assert_pass_finite_R1: assert (!pass_thru ||
        (!(&d_e) && !(&s_e) && !d_zero && !s_zero && result == '0 && !flag_invalid))
        else $error("pass_thru with special operand");
      assert_nan_quiet_R2: assert (!((&result[W-2:MAN_W]) && (|result[MAN_W-1:0])) ||
        result[MAN_W-1] || pass_thru)
        else $error("signaling NaN escaped");
      assert_invalid_nan_R4: assert (!flag_invalid ||
        ((&result[W-2:MAN_W]) && result[MAN_W-1]))
        else $error("invalid without NaN result");
      assert_opp_zero_R7: assert (!(d_zero && s_zero && dst_op[W-1] != s_sign) ||
        result == dst_op)
        else $error("opposite zero sign wrong");
      assert_invalid_src_R11: assert (flag_invalid == (d_snan || s_snan ||
        (d_inf && s_inf && !d_nan && !s_nan && dst_op[W-1] == s_sign)))
        else $error("invalid flag mismatch");
    end
  end
endmodule

// File: tb/sim_fsub_special.sv
module sim_fsub_special;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [63:0] dst_op, src_op, result;
  logic [1:0]  rnd_mode;
  logic        src_is_int, pass_thru, flag_invalid, flag_denorm;
  int checks = 0;
  int errors = 0;

  fsub_special u0 (
    .dst_op(dst_op), .src_op(src_op), .rnd_mode(rnd_mode), .src_is_int(src_is_int),
    .pass_thru(pass_thru), .result(result), .flag_invalid(flag_invalid),
    .flag_denorm(flag_denorm)
  );

  localparam logic [63:0] P_ONE = 64'h3FF0000000000000;
  localparam logic [63:0] N_ONE = 64'hBFF0000000000000;
  localparam logic [63:0] P_TWO = 64'h4000000000000000;
  localparam logic [63:0] P_INF = 64'h7FF0000000000000;
  localparam logic [63:0] N_INF = 64'hFFF0000000000000;
  localparam logic [63:0] P_ZER = 64'h0000000000000000;
  localparam logic [63:0] N_ZER = 64'h8000000000000000;
  localparam logic [63:0] DNAN  = 64'hFFF8000000000000;
  localparam logic [63:0] SNAN  = 64'h7FF0000000000005;
  localparam logic [63:0] QNAN  = 64'hFFF800000000000A;
  localparam logic [63:0] DENRM = 64'h0000000000000001;

  task automatic run(input string tag, input logic [63:0] d, input logic [63:0] s,
                     input logic [1:0] rm, input logic si, input logic e_pass,
                     input logic [63:0] e_res, input logic e_inv, input logic e_den);
    @(negedge clk);
    dst_op = d; src_op = s; rnd_mode = rm; src_is_int = si;
    @(posedge clk);
    checks++;
    if (pass_thru !== e_pass || result !== e_res || flag_invalid !== e_inv ||
        flag_denorm !== e_den) begin
      errors++;
      $display("FAIL %s: got pass=%b res=%h inv=%b den=%b, expected pass=%b res=%h inv=%b den=%b",
               tag, pass_thru, result, flag_invalid, flag_denorm, e_pass, e_res, e_inv, e_den);
    end
  endtask

  task automatic t_pass;
    run("R1 finite pass", P_TWO, P_ONE, 2'b00, 1'b0, 1'b1, 64'h0, 1'b0, 1'b0);
    run("R1 opposite signs pass", P_ONE, N_ONE, 2'b01, 1'b0, 1'b1, 64'h0, 1'b0, 1'b0);
  endtask

  task automatic t_nan;
    run("R2 R3 snan dst quieted", SNAN, P_ONE, 2'b00, 1'b0, 1'b0, 64'h7FF8000000000005, 1'b1, 1'b0);
    run("R2 dst priority", QNAN, SNAN, 2'b00, 1'b0, 1'b0, QNAN, 1'b1, 1'b0);
    run("R2 R11 qnan src", P_INF, QNAN, 2'b00, 1'b0, 1'b0, QNAN, 1'b0, 1'b0);
  endtask

  task automatic t_inf;
    run("R4 inf-inf", P_INF, P_INF, 2'b00, 1'b0, 1'b0, DNAN, 1'b1, 1'b0);
    run("R4 -inf - -inf", N_INF, N_INF, 2'b10, 1'b0, 1'b0, DNAN, 1'b1, 1'b0);
    run("R5 inf - -inf", P_INF, N_INF, 2'b00, 1'b0, 1'b0, P_INF, 1'b0, 1'b0);
    run("R5 dst inf", N_INF, P_TWO, 2'b00, 1'b0, 1'b0, N_INF, 1'b0, 1'b0);
    run("R5 src inf negated", P_ONE, P_INF, 2'b00, 1'b0, 1'b0, N_INF, 1'b0, 1'b0);
  endtask

  task automatic t_zero;
    run("R6 +0-+0 nearest", P_ZER, P_ZER, 2'b00, 1'b0, 1'b0, P_ZER, 1'b0, 1'b0);
    run("R6 +0-+0 down", P_ZER, P_ZER, 2'b01, 1'b0, 1'b0, N_ZER, 1'b0, 1'b0);
    run("R6 equal finite up", P_TWO, P_TWO, 2'b10, 1'b0, 1'b0, P_ZER, 1'b0, 1'b0);
    run("R6 equal finite down", N_ONE, N_ONE, 2'b01, 1'b0, 1'b0, N_ZER, 1'b0, 1'b0);
    run("R6 equal finite trunc", N_ONE, N_ONE, 2'b11, 1'b0, 1'b0, P_ZER, 1'b0, 1'b0);
    run("R7 +0 - -0 down", P_ZER, N_ZER, 2'b01, 1'b0, 1'b0, P_ZER, 1'b0, 1'b0);
    run("R7 -0 - +0 nearest", N_ZER, P_ZER, 2'b00, 1'b0, 1'b0, N_ZER, 1'b0, 1'b0);
  endtask

  task automatic t_int;
    run("R8 int zero taken +0", P_ZER, N_ZER, 2'b01, 1'b1, 1'b0, N_ZER, 1'b0, 1'b0);
    run("R8 int zero -0 dst", N_ZER, N_ZER, 2'b00, 1'b1, 1'b0, N_ZER, 1'b0, 1'b0);
  endtask

  task automatic t_oneside;
    run("R9 zero dst", P_ZER, P_TWO, 2'b00, 1'b0, 1'b0, 64'hC000000000000000, 1'b0, 1'b0);
    run("R9 zero src", N_ONE, P_ZER, 2'b01, 1'b0, 1'b0, N_ONE, 1'b0, 1'b0);
  endtask

  task automatic t_denorm;
    run("R10 denormal src", P_ONE, DENRM, 2'b00, 1'b0, 1'b1, 64'h0, 1'b0, 1'b1);
    run("R10 denormal dst", DENRM, P_ONE, 2'b00, 1'b0, 1'b1, 64'h0, 1'b0, 1'b0);
    run("R10 R9 zero dst denormal src", P_ZER, DENRM, 2'b00, 1'b0, 1'b0, 64'h8000000000000001, 1'b0, 1'b1);
  endtask

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    dst_op = '0; src_op = '0; rnd_mode = 2'b00; src_is_int = 1'b0;
    run("R6 R11 reset inputs", P_ZER, P_ZER, 2'b00, 1'b0, 1'b0, P_ZER, 1'b0, 1'b0);
    t_pass();
    t_nan();
    t_inf();
    t_zero();
    t_int();
    t_oneside();
    t_denorm();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule